// File: doc/BRIEF.md
# Burst-of-two ECC SRAM core

This block is a synthesizable behavioural model of a separate-I/O, double-data-rate memory core that moves data in bursts of two beats. It runs on a beat clock: every memory cycle spans two consecutive edges. The first edge after reset release is a rising phase and the two phases alternate from then on. Commands are taken only on rising-phase edges. In each cycle the core can accept one read and one write, and each has its own address port.

A write takes its lower beat with the command and its upper beat on the following falling phase. It joins the two beats into one double-width word, adds a single-error-correcting, double-error-detecting code, and stores the result. A read fetches one stored codeword and repairs any single flipped bit. After a fixed latency it drives the lower half of the word and then the upper half on the read bus. Because every stored word holds two beats, the word address has one bit fewer than the beat depth would need.

An injection mask is XORed into the codeword as it is stored. A flag reports each read that needed a repair, and a second flag reports each read that could not be repaired.

Top module: `sram_b2_core`

## Requirements
- R1: A write takes `wrData` as the lower beat at the rising-phase edge where `wrEn` is high, and as the upper beat at the falling-phase edge that follows. The two beats are stored together as one word at `wrAddr`.
- R2: A read issued at rising-phase edge E drives the lower half of the word on `rdData` after edge E+2*READ_LAT (E+10 by default) and the upper half after edge E+2*READ_LAT+1. `rdValid` is high on exactly those two beats.
- R3: When no read result is due, `rdValid`, `corFlag` and `dedFlag` are all low.
- R4: A read and a write to different addresses may be issued in the same cycle, and in every cycle back to back, with no lost or stalled operation.
- R5: When a read and a write target the same address in the same cycle, the read returns the word stored before that write. A read of that address in the next cycle returns the new word.
- R6: The XOR of `injMask` with a single bit set corrupts one bit of the stored CODE_W-bit codeword (bit 0 is the overall parity bit). A later read of that word returns the data as written, with `corFlag` high on both beats and `dedFlag` low.
- R7: When exactly two bits of a stored codeword are corrupted, a read raises `dedFlag` on both beats and keeps `corFlag` low.
- R8: A read of an uncorrupted word raises neither flag.
- R9: Each of the 2^ADDR_W word addresses holds its own word. The beat depth is 2^(ADDR_W+1).
- R10: While reset is active and after it is released, `rdValid` and both flags are low. The first edge after release is a rising phase.
- R11: `rdEn` and `wrEn` presented at a falling-phase edge are ignored. No read result appears and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges form one memory cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read request, sampled at rising-phase edges |
| rdAddr | input | ADDR_W | Read word address |
| wrEn | input | 1 | Write request, sampled at rising-phase edges |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | BEAT_W | Write beat: lower half at the rising phase, upper half at the falling phase |
| injMask | input | CODE_W | Bits XORed into the codeword being stored, sampled with the write |
| rdData | output | BEAT_W | Read beat: lower half first, then upper half |
| rdValid | output | 1 | High while `rdData` carries a read beat |
| corFlag | output | 1 | The word on `rdData` had one bit repaired |
| dedFlag | output | 1 | The word on `rdData` has an error that cannot be repaired |

## Verification
If the phase counter slips, the beats appear swapped or the command is taken on the wrong edge. Either shows up as wrong data within ten edges of the first read after the slip. A fault in a pipeline stage's valid bit shows up as `rdValid` one cycle early or late, or missing altogether, on the next isolated read. A coding fault appears on the first read of a word with an injected flip: the data is wrong or the flags are wrong. The same-cycle read-write case separates a forwarding path from a true read-before-write order at the first such pair.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  localparam int ECC_MAX_W = 512;

  typedef struct packed {
    logic edgeRise;
    logic edgeFall;
    logic capWr;
    logic commitWr;
    logic capRd;
    logic fetchRd;
  } strobe_t;

  function automatic int eccCheckBits(input int dataW);
    int p;
    p = 0;
    for (int i = 1; i < 16; i++)
      if (p == 0 && (1 << i) >= dataW + i + 1) p = i;
    return p;
  endfunction

  function automatic logic [ECC_MAX_W-1:0] eccCover(input int bitIdx, input int last);
    logic [ECC_MAX_W-1:0] m;
    m = '0;
    for (int pos = 1; pos < ECC_MAX_W; pos++)
      if (pos <= last && ((pos >> bitIdx) & 1) == 1) m[pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sram_b2_ecc_enc.sv
module sram_b2_ecc_enc
  import sram_b2_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic [DATA_W-1:0]                          dataIn,
  output logic [DATA_W+eccCheckBits(DATA_W):0]       codeOut
);
  localparam int PAR_W = eccCheckBits(DATA_W);
  localparam int LAST  = DATA_W + PAR_W;

  function automatic logic [LAST:1] spread(input logic [DATA_W-1:0] d);
    logic [LAST:1] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= LAST; pos++)
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[k];
        k++;
      end
    return c;
  endfunction

  logic [LAST:1]    spreadWord;
  logic [PAR_W-1:0] parity;
  logic [LAST:1]    body;

  assign spreadWord = spread(dataIn);

  for (genvar p = 0; p < PAR_W; p++) begin : g_par
    localparam logic [ECC_MAX_W-1:0] COV = eccCover(p, LAST);
    assign parity[p] = ^(spreadWord & COV[LAST:1]);
  end

  always_comb begin
    body = spreadWord;
    for (int p = 0; p < PAR_W; p++) body[1 << p] = parity[p];
    codeOut = {body, ^body};
  end

endmodule

// File: rtl/sram_b2_ecc_dec.sv
module sram_b2_ecc_dec
  import sram_b2_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic [DATA_W+eccCheckBits(DATA_W):0] codeIn,
  output logic [DATA_W-1:0]                    dataOut,
  output logic                                 corrected,
  output logic                                 uncorrectable
);
  localparam int PAR_W = eccCheckBits(DATA_W);
  localparam int LAST  = DATA_W + PAR_W;

  function automatic logic [DATA_W-1:0] gather(input logic [LAST:1] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= LAST; pos++)
      if ((pos & (pos - 1)) != 0) begin
        d[k] = c[pos];
        k++;
      end
    return d;
  endfunction

  logic [PAR_W-1:0] syn;
  logic             overall;
  logic             hasSyn;
  logic             synBeyond;
  logic [LAST:1]    flip;

  for (genvar p = 0; p < PAR_W; p++) begin : g_syn
    localparam logic [ECC_MAX_W-1:0] COV = eccCover(p, LAST);
    assign syn[p] = ^(codeIn[LAST:1] & COV[LAST:1]);
  end

  assign overall   = ^codeIn;
  assign hasSyn    = |syn;
  assign synBeyond = (32'(syn) > 32'(LAST));

  for (genvar pos = 1; pos <= LAST; pos++) begin : g_flip
    assign flip[pos] = overall && (syn == PAR_W'(pos));
  end

  assign dataOut       = gather(codeIn[LAST:1] ^ flip);
  assign corrected     = overall && !synBeyond;
  assign uncorrectable = hasSyn && (!overall || synBeyond);

endmodule

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl
  import sram_b2_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdEn,
  input  logic    wrEn,
  output strobe_t strobes
);
  logic phaseQ;
  logic wrPendQ;
  logic rdPendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      wrPendQ <= 1'b0;
      rdPendQ <= 1'b0;
    end else begin
      phaseQ  <= ~phaseQ;
      wrPendQ <= ~phaseQ & wrEn;
      rdPendQ <= ~phaseQ & rdEn;
    end
  end

  always_comb begin
    strobes.edgeRise = ~phaseQ;
    strobes.edgeFall = phaseQ;
    strobes.capWr    = ~phaseQ & wrEn;
    strobes.commitWr = phaseQ & wrPendQ;
    strobes.capRd    = ~phaseQ & rdEn;
    strobes.fetchRd  = phaseQ & rdPendQ;
  end

  assert_fall_no_cap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capWr || strobes.capRd) |=> !(strobes.capWr || strobes.capRd));

endmodule

// File: rtl/sram_b2_datapath.sv
module sram_b2_datapath
  import sram_b2_pkg::*;
#(
  parameter int BEAT_W   = 18,
  parameter int ADDR_W   = 6,
  parameter int READ_LAT = 5
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  strobe_t                                 strobes,
  input  logic [ADDR_W-1:0]                       rdAddr,
  input  logic [ADDR_W-1:0]                       wrAddr,
  input  logic [BEAT_W-1:0]                       wrData,
  input  logic [2*BEAT_W+eccCheckBits(2*BEAT_W):0] injMask,
  output logic [BEAT_W-1:0]                       rdData,
  output logic                                    rdValid,
  output logic                                    corFlag,
  output logic                                    dedFlag
);
  localparam int WORD_W = 2 * BEAT_W;
  localparam int CODE_W = WORD_W + eccCheckBits(WORD_W) + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PIPE_D = READ_LAT - 1;

  typedef struct packed {
    logic              valid;
    logic              cor;
    logic              ded;
    logic [WORD_W-1:0] word;
  } stage_t;

  // write side
  logic [BEAT_W-1:0] wrLoQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [CODE_W-1:0] injQ;
  logic [CODE_W-1:0] wrCode;
  logic [CODE_W-1:0] memQ [DEPTH];

  // read side
  logic [ADDR_W-1:0] rdAddrQ;
  logic [CODE_W-1:0] fetchQ;
  logic              fetchValidQ;
  logic [WORD_W-1:0] decWord;
  logic              decCor;
  logic              decDed;
  stage_t            head;
  stage_t            stageQ [PIPE_D];
  logic [BEAT_W-1:0] hiHoldQ;

  always_ff @(posedge clk) begin
    if (strobes.capWr) begin
      wrLoQ   <= wrData;
      wrAddrQ <= wrAddr;
      injQ    <= injMask;
    end
    if (strobes.capRd) rdAddrQ <= rdAddr;
  end

  sram_b2_ecc_enc #(.DATA_W(WORD_W)) u_enc (
    .dataIn  ({wrData, wrLoQ}),
    .codeOut (wrCode)
  );

  // array: the fetch at the commit edge sees the old word
  always_ff @(posedge clk) begin
    if (strobes.commitWr) memQ[wrAddrQ] <= wrCode ^ injQ;
    if (strobes.fetchRd)  fetchQ <= memQ[rdAddrQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fetchValidQ <= 1'b0;
    else if (strobes.edgeFall) fetchValidQ <= strobes.fetchRd;
  end

  sram_b2_ecc_dec #(.DATA_W(WORD_W)) u_dec (
    .codeIn        (fetchQ),
    .dataOut       (decWord),
    .corrected     (decCor),
    .uncorrectable (decDed)
  );

  always_comb begin
    head.valid = fetchValidQ;
    head.cor   = fetchValidQ & decCor;
    head.ded   = fetchValidQ & decDed;
    head.word  = decWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIPE_D; i++) stageQ[i] <= '0;
    end else if (strobes.edgeRise) begin
      stageQ[0] <= head;
      for (int i = 1; i < PIPE_D; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  // output mux: lower half on the rising phase, upper half on the falling phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      hiHoldQ <= '0;
      rdValid <= 1'b0;
      corFlag <= 1'b0;
      dedFlag <= 1'b0;
    end else if (strobes.edgeRise) begin
      rdData  <= stageQ[PIPE_D-1].word[BEAT_W-1:0];
      hiHoldQ <= stageQ[PIPE_D-1].word[WORD_W-1:BEAT_W];
      rdValid <= stageQ[PIPE_D-1].valid;
      corFlag <= stageQ[PIPE_D-1].cor;
      dedFlag <= stageQ[PIPE_D-1].ded;
    end else begin
      rdData  <= hiHoldQ;
    end
  end

  assert_commit_after_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWr |-> $past(strobes.capWr));

  assert_fetch_after_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capRd |=> strobes.fetchRd);

  assert_valid_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid);

  assert_valid_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdValid) |-> $past(strobes.edgeRise));

  assert_flag_needs_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (corFlag || dedFlag) |-> rdValid);

  assert_flag_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(corFlag && dedFlag));

endmodule

// File: rtl/sram_b2_core.sv
module sram_b2_core
  import sram_b2_pkg::*;
#(
  parameter int BEAT_W   = 18,
  parameter int ADDR_W   = 6,
  parameter int READ_LAT = 5
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     rdEn,
  input  logic [ADDR_W-1:0]                        rdAddr,
  input  logic                                     wrEn,
  input  logic [ADDR_W-1:0]                        wrAddr,
  input  logic [BEAT_W-1:0]                        wrData,
  input  logic [2*BEAT_W+eccCheckBits(2*BEAT_W):0] injMask,
  output logic [BEAT_W-1:0]                        rdData,
  output logic                                     rdValid,
  output logic                                     corFlag,
  output logic                                     dedFlag
);
  strobe_t strobes;

  sram_b2_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  sram_b2_datapath #(
    .BEAT_W   (BEAT_W),
    .ADDR_W   (ADDR_W),
    .READ_LAT (READ_LAT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdAddr  (rdAddr),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .injMask (injMask),
    .rdData  (rdData),
    .rdValid (rdValid),
    .corFlag (corFlag),
    .dedFlag (dedFlag)
  );

endmodule

// File: tb/sim_sram_b2_core.sv
module sim_sram_b2_core;
  import sram_b2_pkg::*;

  localparam int BEAT_W = 18;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 2 * BEAT_W;
  localparam int CODE_W = WORD_W + eccCheckBits(WORD_W) + 1;
  localparam int LATB   = 10;
  localparam int MAXB   = 8192;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [BEAT_W-1:0] wrData = '0;
  logic [CODE_W-1:0] injMask = '0;
  logic [BEAT_W-1:0] rdData;
  logic              rdValid;
  logic              corFlag;
  logic              dedFlag;

  sram_b2_core u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .injMask(injMask), .rdData(rdData),
    .rdValid(rdValid), .corFlag(corFlag), .dedFlag(dedFlag)
  );

  always #2.5 clk = ~clk;

  int checkCnt = 0;
  int failCnt  = 0;
  int posCnt   = 0;
  bit done     = 0;

  logic [WORD_W-1:0] modelMem [1 << ADDR_W];
  logic [BEAT_W-1:0] gotData  [MAXB];
  logic              gotValid [MAXB];
  logic              gotCor   [MAXB];
  logic              gotDed   [MAXB];

  always @(posedge clk) if (rstN) posCnt <= posCnt + 1;

  always @(negedge clk)
    if (rstN && posCnt > 0 && posCnt <= MAXB) begin
      gotData[posCnt-1]  = rdData;
      gotValid[posCnt-1] = rdValid;
      gotCor[posCnt-1]   = corFlag;
      gotDed[posCnt-1]   = dedFlag;
    end

  task automatic check(input bit ok, input string req, input string msg);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic cycleOp(input bit rd, input int ra, input bit wr, input int wa,
                         input logic [WORD_W-1:0] dat, input logic [CODE_W-1:0] mask,
                         output int e, output logic [WORD_W-1:0] rdExp);
    @(negedge clk);
    if (posCnt % 2 == 1) @(negedge clk);
    e = posCnt;
    rdExp = modelMem[ra];
    rdEn = rd; rdAddr = ADDR_W'(ra);
    wrEn = wr; wrAddr = ADDR_W'(wa);
    wrData = dat[BEAT_W-1:0]; injMask = mask;
    if (wr) modelMem[wa] = dat;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    wrData = dat[WORD_W-1:BEAT_W]; injMask = '0;
  endtask

  task automatic waitEdge(input int edgeNo);
    while (posCnt <= edgeNo) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkRead(input int e, input logic [WORD_W-1:0] exp, input bit expCor,
                           input bit expDed, input string req);
    waitEdge(e + LATB + 1);
    check(gotValid[e+LATB] && gotValid[e+LATB+1], req,
          $sformatf("rdValid beats got %0b%0b exp 11 (cmd edge %0d)",
                    gotValid[e+LATB], gotValid[e+LATB+1], e));
    if (!expDed)
      check(gotData[e+LATB] == exp[BEAT_W-1:0] && gotData[e+LATB+1] == exp[WORD_W-1:BEAT_W], req,
            $sformatf("data lo/hi got %h/%h exp %h/%h", gotData[e+LATB], gotData[e+LATB+1],
                      exp[BEAT_W-1:0], exp[WORD_W-1:BEAT_W]));
    check(gotCor[e+LATB] == expCor && gotCor[e+LATB+1] == expCor &&
          gotDed[e+LATB] == expDed && gotDed[e+LATB+1] == expDed, req,
          $sformatf("flags cor %0b%0b ded %0b%0b exp cor %0b ded %0b", gotCor[e+LATB],
                    gotCor[e+LATB+1], gotDed[e+LATB], gotDed[e+LATB+1], expCor, expDed));
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!rdValid && !corFlag && !dedFlag, "R10",
            $sformatf("in reset valid/cor/ded got %0b%0b%0b exp 000", rdValid, corFlag, dedFlag));
    end
    #1 rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!rdValid && !corFlag && !dedFlag, "R10",
          $sformatf("after reset valid/cor/ded got %0b%0b%0b exp 000", rdValid, corFlag, dedFlag));
  endtask

  task automatic testBasic();
    int e, d;
    logic [WORD_W-1:0] x;
    cycleOp(0, 0, 1, 5, 36'h9_A5C3_1F07, '0, d, x);
    cycleOp(1, 5, 0, 0, '0, '0, e, x);
    checkRead(e, 36'h9_A5C3_1F07, 0, 0, "R1 R2 R8 R10");
    check(!gotValid[e+LATB-1] && !gotValid[e+LATB+2], "R2",
          $sformatf("valid before/after window got %0b/%0b exp 0/0",
                    gotValid[e+LATB-1], gotValid[e+LATB+2]));
  endtask

  task automatic testBackToBack();
    int e [5];
    logic [WORD_W-1:0] ex [5];
    for (int i = 0; i < 5; i++)
      cycleOp(1, (i == 0) ? 5 : 19 + i, 1, 20 + i, 36'h1_0000_0001 * (i + 3) ^ 36'h5_5AA5_0F0F,
              '0, e[i], ex[i]);
    for (int i = 0; i < 5; i++) checkRead(e[i], ex[i], 0, 0, "R4");
  endtask

  task automatic testSameAddr();
    int e1, e2, d;
    logic [WORD_W-1:0] x1, x2;
    cycleOp(0, 0, 1, 10, 36'h1_1111_2222, '0, d, x1);
    cycleOp(1, 10, 1, 10, 36'hE_EEEE_DDDD, '0, e1, x1);
    cycleOp(1, 10, 0, 0, '0, '0, e2, x2);
    check(x1 == 36'h1_1111_2222 && x2 == 36'hE_EEEE_DDDD, "R5", "bench model order");
    checkRead(e1, 36'h1_1111_2222, 0, 0, "R5");
    checkRead(e2, 36'hE_EEEE_DDDD, 0, 0, "R5");
  endtask

  task automatic testSingleErr();
    int bits [5] = '{0, 1, 5, 20, CODE_W - 1};
    for (int i = 0; i < 5; i++) begin
      int e, d;
      logic [WORD_W-1:0] x;
      logic [WORD_W-1:0] v;
      v = 36'h3_C3C3_5A5A ^ WORD_W'(i * 977);
      cycleOp(0, 0, 1, 30 + i, v, CODE_W'(1) << bits[i], d, x);
      cycleOp(1, 30 + i, 0, 0, '0, '0, e, x);
      checkRead(e, v, 1, 0, "R6");
    end
  endtask

  task automatic testDoubleErr();
    int e, d;
    logic [WORD_W-1:0] x;
    cycleOp(0, 0, 1, 40, 36'h7_0F0F_1234, (CODE_W'(1) << 3) | (CODE_W'(1) << 17), d, x);
    cycleOp(1, 40, 0, 0, '0, '0, e, x);
    checkRead(e, x, 0, 1, "R7");
  endtask

  task automatic testIdle();
    int start;
    bit quiet;
    repeat (30) @(negedge clk);
    start = posCnt;
    repeat (20) @(negedge clk);
    @(negedge clk);
    quiet = 1;
    for (int b = start; b < start + 20; b++)
      if (gotValid[b] || gotCor[b] || gotDed[b]) quiet = 0;
    check(quiet, "R3", $sformatf("idle window outputs active got %0b exp 1", quiet));
  endtask

  task automatic testFallIgnored();
    int e, d, f;
    logic [WORD_W-1:0] x;
    bit quiet;
    cycleOp(0, 0, 1, 50, 36'h2_4680_ACE1, '0, d, x);
    @(negedge clk);
    if (posCnt % 2 == 0) @(negedge clk);
    f = posCnt;
    rdEn = 1'b1; rdAddr = 50; wrEn = 1'b1; wrAddr = 50; wrData = '1;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; wrData = '0;
    waitEdge(f + 16);
    quiet = 1;
    for (int b = f; b <= f + 16; b++) if (gotValid[b]) quiet = 0;
    check(quiet, "R11", $sformatf("read at falling phase produced output got %0b exp 1", quiet));
    cycleOp(1, 50, 0, 0, '0, '0, e, x);
    checkRead(e, 36'h2_4680_ACE1, 0, 0, "R11");
  endtask

  task automatic testSweep();
    int e [1 << ADDR_W];
    logic [WORD_W-1:0] x;
    bit allOk;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      int d;
      cycleOp(0, 0, 1, a, WORD_W'(a) * 36'h0_0421_0843 ^ 36'hA_5000_0000, '0, d, x);
    end
    for (int a = 0; a < (1 << ADDR_W); a++) cycleOp(1, a, 0, 0, '0, '0, e[a], x);
    waitEdge(e[(1 << ADDR_W) - 1] + LATB + 1);
    allOk = 1;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      logic [WORD_W-1:0] v;
      v = WORD_W'(a) * 36'h0_0421_0843 ^ 36'hA_5000_0000;
      if (!gotValid[e[a]+LATB] || gotData[e[a]+LATB] != v[BEAT_W-1:0] ||
          gotData[e[a]+LATB+1] != v[WORD_W-1:BEAT_W]) begin
        allOk = 0;
        $display("FAIL R9: addr %0d got %h/%h exp %h/%h", a, gotData[e[a]+LATB],
                 gotData[e[a]+LATB+1], v[BEAT_W-1:0], v[WORD_W-1:BEAT_W]);
      end
    end
    checkCnt++;
    if (!allOk) failCnt++;
  endtask

  initial begin
    testReset();
    testBasic();
    testBackToBack();
    testSameAddr();
    testSingleErr();
    testDoubleErr();
    testIdle();
    testFallIgnored();
    testSweep();
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule